// File: doc/BRIEF.md
# Upconverter Channel Settings Bank

This block holds the run-time settings of a multichannel digital upconverter. A host writes 32-bit words over a simple byte-addressed write port. The block decodes each address into a channel and a register, and keeps the settings that the datapath of that channel uses. The settings are the packed interpolation word (halfband stage count and CIC rate), the numerator and denominator of the rate change, a configuration word, the NCO phase increment, the IQ scale factor and the time increment in ticks per output sample. Every setting drives an output bus, one 32-bit slice per channel.

Channels sit at a fixed stride of 2048 bytes. Within a bank, register index k is at byte offset 8·k. A read port returns the live settings. It also returns three constant identification words that describe the build: the compatibility number, the number of halfband stages and the largest CIC rate. Software uses these to work out which interpolation values are legal.

A phase-increment write can be marked as timed. A timed write is held in a per-channel pending slot until a free-running timebase input reaches its command time, so that a frequency hop lands on a known sample. All other writes apply at once.

Top module: `duc_cfg_bank`

## Requirements
- R1: After reset, every channel has interpolation word 1, rate numerator 1, rate denominator 1, configuration 0, phase increment 0, scale factor 0x8000 (unity in Q15) and time increment 0.
- R2: The channel of a byte address is `addr >> 11`. A write changes the settings of that channel only.
- R3: Within a bank the byte offsets are: rate denominator 1024 (index 128), rate numerator 1032 (129), configuration 1040 (130), interpolation 1048 (131), phase increment 1056 (132), scale 1064 (133) and time increment 1096 (137). An untimed write is visible on the setting output and on readback one clock edge after it is accepted. No setting changes in a cycle without a write, except through R7.
- R4: Interpolation word: bits 15:8 hold the halfband count and bits 7:0 hold the CIC rate. A write is accepted only if the count is at most NUM_HB and the rate is between 1 and CIC_MAX. It is then stored with bits 31:16 cleared. A rejected write leaves the word unchanged.
- R5: Reads at offset 0 return {COMPAT_MAJOR, COMPAT_MINOR} (major in bits 31:16). Offset 8 returns NUM_HB and offset 16 returns CIC_MAX. These three words are the same in every channel bank.
- R6: Writes are ignored and reads return 0 in three cases: the address has bits 2:0 nonzero, the channel is NCHAN or above, or the index is not one listed in R3 or R5.
- R7: A timed phase-increment write whose command time is later than the timebase is held pending. It reaches the output at the first clock edge at which the timebase is at least the command time. A newer timed write replaces the pending one.
- R8: A timed phase-increment write whose command time is equal to or earlier than the timebase applies at once. The timed flag has no effect on any other register.
- R9: An untimed phase-increment write applies at once and discards any pending timed write of that channel.
- R10: Read data is registered. It is valid one edge after a cycle with `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| wr_timed | input | 1 | Hold a phase-increment write for its command time |
| wr_time | input | TIME_W | Command time of a timed write |
| now_time | input | TIME_W | Timebase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| interp_o | output | 32·NCHAN | Interpolation word per channel |
| rate_m_o | output | 32·NCHAN | Rate-change numerator per channel |
| rate_n_o | output | 32·NCHAN | Rate-change denominator per channel |
| cfg_o | output | 32·NCHAN | Configuration word per channel |
| freq_o | output | 32·NCHAN | NCO phase increment per channel |
| scale_o | output | 32·NCHAN | IQ scale factor per channel |
| tincr_o | output | 32·NCHAN | Ticks per output sample per channel |

## Verification
The bench builds the block with NCHAN=2, NUM_HB=2, CIC_MAX=8, ADDR_W=16 and TIME_W=16. The small halfband and CIC limits let the bench write every combination of halfband count 0 to 3 and CIC rate 0 to 9, which covers both sides of each acceptance bound. The 16-bit address holds a third, nonexistent channel bank. The bench reads all 256 aligned offsets in each of the three banks, so every defined and undefined index is read in both real channels and in the missing one.

// File: rtl/duc_cfg_pkg.sv
package duc_cfg_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] IDX_COMPAT = 8'd0;
    localparam logic [7:0] IDX_NHB    = 8'd1;
    localparam logic [7:0] IDX_CICMAX = 8'd2;
    localparam logic [7:0] IDX_RATE_N = 8'd128;
    localparam logic [7:0] IDX_RATE_M = 8'd129;
    localparam logic [7:0] IDX_CFG    = 8'd130;
    localparam logic [7:0] IDX_INTERP = 8'd131;
    localparam logic [7:0] IDX_FREQ   = 8'd132;
    localparam logic [7:0] IDX_SCALE  = 8'd133;
    localparam logic [7:0] IDX_TINCR  = 8'd137;

    localparam logic [REG_W-1:0] SCALE_UNITY = 32'h0000_8000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_COMPAT, SEL_NHB, SEL_CICMAX,
        SEL_RATE_N, SEL_RATE_M, SEL_CFG, SEL_INTERP,
        SEL_FREQ, SEL_SCALE, SEL_TINCR
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] rate_n;
        logic [REG_W-1:0] rate_m;
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] interp;
        logic [REG_W-1:0] freq;
        logic [REG_W-1:0] scale;
        logic [REG_W-1:0] tincr;
    } chan_regs_t;

    function automatic reg_sel_e index_to_sel(input logic [7:0] idx);
        case (idx)
            IDX_COMPAT: return SEL_COMPAT;
            IDX_NHB:    return SEL_NHB;
            IDX_CICMAX: return SEL_CICMAX;
            IDX_RATE_N: return SEL_RATE_N;
            IDX_RATE_M: return SEL_RATE_M;
            IDX_CFG:    return SEL_CFG;
            IDX_INTERP: return SEL_INTERP;
            IDX_FREQ:   return SEL_FREQ;
            IDX_SCALE:  return SEL_SCALE;
            IDX_TINCR:  return SEL_TINCR;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_writable(input reg_sel_e s);
        return (s == SEL_RATE_N) || (s == SEL_RATE_M) || (s == SEL_CFG) ||
               (s == SEL_INTERP) || (s == SEL_FREQ) || (s == SEL_SCALE) ||
               (s == SEL_TINCR);
    endfunction

    function automatic logic interp_legal(input logic [REG_W-1:0] w,
                                          input int unsigned num_hb,
                                          input int unsigned cic_max);
        int unsigned hb;
        int unsigned cic;
        hb  = int'(w[15:8]);
        cic = int'(w[7:0]);
        return (hb <= num_hb) && (cic >= 1) && (cic <= cic_max);
    endfunction

endpackage

// File: rtl/duc_cfg_decode.sv
module duc_cfg_decode
    import duc_cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NCHAN  = 2,
    parameter int CH_W   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CH_W-1:0]   chan,
    output reg_sel_e          sel
);
    localparam int STRIDE_LSB = 11;
    localparam int CHF_W      = ADDR_W - STRIDE_LSB;

    logic [CHF_W-1:0] chan_full;

    always_comb begin
        chan_full = addr[ADDR_W-1:STRIDE_LSB];
        chan      = CH_W'(chan_full);
        sel       = index_to_sel(addr[10:3]);
        hit       = (addr[2:0] == 3'b000) && (int'(chan_full) < NCHAN) &&
                    (sel != SEL_NONE);
    end
endmodule

// File: rtl/duc_cfg_chan.sv
module duc_cfg_chan
    import duc_cfg_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int NUM_HB  = 2,
    parameter int CIC_MAX = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic              timed,
    input  logic [TIME_W-1:0] wtime,
    input  logic [TIME_W-1:0] now_time,
    output chan_regs_t        regs
);
    logic              pend_v;
    logic [REG_W-1:0]  pend_word;
    logic [TIME_W-1:0] pend_time;
    logic              pend_due;
    logic              wr_future;

    assign pend_due  = pend_v && (now_time >= pend_time);
    assign wr_future = timed && (wtime > now_time);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.rate_n <= 32'd1;
            regs.rate_m <= 32'd1;
            regs.cfg    <= '0;
            regs.interp <= 32'd1;
            regs.freq   <= '0;
            regs.scale  <= SCALE_UNITY;
            regs.tincr  <= '0;
            pend_v      <= 1'b0;
            pend_word   <= '0;
            pend_time   <= '0;
        end else begin
            if (pend_due) begin
                regs.freq <= pend_word;
                pend_v    <= 1'b0;
            end
            if (we) begin
                case (sel)
                    SEL_RATE_N: regs.rate_n <= wdata;
                    SEL_RATE_M: regs.rate_m <= wdata;
                    SEL_CFG:    regs.cfg    <= wdata;
                    SEL_SCALE:  regs.scale  <= wdata;
                    SEL_TINCR:  regs.tincr  <= wdata;
                    SEL_INTERP: begin
                        if (interp_legal(wdata, NUM_HB, CIC_MAX))
                            regs.interp <= {16'h0000, wdata[15:0]};
                    end
                    SEL_FREQ: begin
                        if (wr_future) begin
                            pend_v    <= 1'b1;
                            pend_word <= wdata;
                            pend_time <= wtime;
                        end else begin
                            regs.freq <= wdata;
                            pend_v    <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/duc_cfg_bank.sv
module duc_cfg_bank
    import duc_cfg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int TIME_W       = 64,
    parameter int NCHAN        = 2,
    parameter int NUM_HB       = 2,
    parameter int CIC_MAX      = 128,
    parameter int COMPAT_MAJOR = 0,
    parameter int COMPAT_MINOR = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic                    wr_timed,
    input  logic [TIME_W-1:0]       wr_time,
    input  logic [TIME_W-1:0]       now_time,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [31:0]             rd_data,
    output logic [NCHAN*32-1:0]     interp_o,
    output logic [NCHAN*32-1:0]     rate_m_o,
    output logic [NCHAN*32-1:0]     rate_n_o,
    output logic [NCHAN*32-1:0]     cfg_o,
    output logic [NCHAN*32-1:0]     freq_o,
    output logic [NCHAN*32-1:0]     scale_o,
    output logic [NCHAN*32-1:0]     tincr_o
);
    localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;
    localparam logic [31:0] COMPAT_WORD = {COMPAT_MAJOR[15:0], COMPAT_MINOR[15:0]};

    logic            w_hit, r_hit;
    logic [CH_W-1:0] w_chan, r_chan;
    reg_sel_e        w_sel, r_sel;
    chan_regs_t      ch_regs [NCHAN];
    logic [31:0]     rd_next;

    duc_cfg_decode #(.ADDR_W(ADDR_W), .NCHAN(NCHAN), .CH_W(CH_W)) u_wdec (
        .addr(wr_addr), .hit(w_hit), .chan(w_chan), .sel(w_sel)
    );

    duc_cfg_decode #(.ADDR_W(ADDR_W), .NCHAN(NCHAN), .CH_W(CH_W)) u_rdec (
        .addr(rd_addr), .hit(r_hit), .chan(r_chan), .sel(r_sel)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic we_c;
        assign we_c = wr_en && w_hit && is_writable(w_sel) && (int'(w_chan) == c);

        duc_cfg_chan #(.TIME_W(TIME_W), .NUM_HB(NUM_HB), .CIC_MAX(CIC_MAX)) u_chan (
            .clk(clk), .rst(rst), .we(we_c), .sel(w_sel), .wdata(wr_data),
            .timed(wr_timed), .wtime(wr_time), .now_time(now_time),
            .regs(ch_regs[c])
        );

        assign interp_o[c*32 +: 32] = ch_regs[c].interp;
        assign rate_m_o[c*32 +: 32] = ch_regs[c].rate_m;
        assign rate_n_o[c*32 +: 32] = ch_regs[c].rate_n;
        assign cfg_o[c*32 +: 32]    = ch_regs[c].cfg;
        assign freq_o[c*32 +: 32]   = ch_regs[c].freq;
        assign scale_o[c*32 +: 32]  = ch_regs[c].scale;
        assign tincr_o[c*32 +: 32]  = ch_regs[c].tincr;
    end

    always_comb begin
        chan_regs_t sel_regs;
        sel_regs = '0;
        for (int c = 0; c < NCHAN; c++)
            if (int'(r_chan) == c) sel_regs = ch_regs[c];
        rd_next = '0;
        if (r_hit) begin
            case (r_sel)
                SEL_COMPAT: rd_next = COMPAT_WORD;
                SEL_NHB:    rd_next = 32'(NUM_HB);
                SEL_CICMAX: rd_next = 32'(CIC_MAX);
                SEL_RATE_N: rd_next = sel_regs.rate_n;
                SEL_RATE_M: rd_next = sel_regs.rate_m;
                SEL_CFG:    rd_next = sel_regs.cfg;
                SEL_INTERP: rd_next = sel_regs.interp;
                SEL_FREQ:   rd_next = sel_regs.freq;
                SEL_SCALE:  rd_next = sel_regs.scale;
                SEL_TINCR:  rd_next = sel_regs.tincr;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/duc_cfg_bank_chk.sv
module duc_cfg_bank_chk #(
    parameter int ADDR_W       = 16,
    parameter int NCHAN        = 2,
    parameter int NUM_HB       = 2,
    parameter int CIC_MAX      = 128,
    parameter int COMPAT_MAJOR = 0,
    parameter int COMPAT_MINOR = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [31:0]         rd_data,
    input logic [NCHAN*32-1:0] interp_o,
    input logic [NCHAN*32-1:0] rate_m_o,
    input logic [NCHAN*32-1:0] rate_n_o,
    input logic [NCHAN*32-1:0] cfg_o,
    input logic [NCHAN*32-1:0] freq_o,
    input logic [NCHAN*32-1:0] scale_o,
    input logic [NCHAN*32-1:0] tincr_o
);
    logic undef_rd;
    always_comb begin
        int unsigned off;
        off = int'(rd_addr[10:0]);
        undef_rd = 1'b1;
        if ((rd_addr[2:0] == 3'b000) && (int'(rd_addr >> 11) < NCHAN))
            undef_rd = !(off == 0 || off == 8 || off == 16 ||
                         (off >= 1024 && off <= 1064) || off == 1096);
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_c
        assert_interp_legal_R4: assert property (@(posedge clk) disable iff (rst)
            (interp_o[c*32+16 +: 16] == 16'h0) && (int'(interp_o[c*32+8 +: 8]) <= NUM_HB) &&
            (interp_o[c*32 +: 8] != 8'h0) && (int'(interp_o[c*32 +: 8]) <= CIC_MAX));

        assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (interp_o[c*32 +: 32] == 32'd1) && (freq_o[c*32 +: 32] == 32'd0) &&
                           (scale_o[c*32 +: 32] == 32'h8000));
    end

    assert_quiet_settings_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(interp_o) && $stable(rate_m_o) && $stable(rate_n_o) &&
                          $stable(cfg_o) && $stable(scale_o) && $stable(tincr_o));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rd_data));

    assert_undef_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && undef_rd) |-> (rd_data == 32'd0));

    assert_compat_word_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && (rd_addr == '0)) |->
            (rd_data == {COMPAT_MAJOR[15:0], COMPAT_MINOR[15:0]}));
endmodule

bind duc_cfg_bank duc_cfg_bank_chk #(
    .ADDR_W(ADDR_W), .NCHAN(NCHAN), .NUM_HB(NUM_HB), .CIC_MAX(CIC_MAX),
    .COMPAT_MAJOR(COMPAT_MAJOR), .COMPAT_MINOR(COMPAT_MINOR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .interp_o(interp_o), .rate_m_o(rate_m_o),
    .rate_n_o(rate_n_o), .cfg_o(cfg_o), .freq_o(freq_o), .scale_o(scale_o),
    .tincr_o(tincr_o)
);

// File: tb/sim_duc_cfg_bank.sv
`timescale 1ns/1ps
module sim_duc_cfg_bank;
    localparam int AW = 16, TW = 16, NC = 2, NHB = 2, CMAX = 8;
    localparam int MAJ = 0, MIN = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_timed = 0, rd_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [TW-1:0] wr_time = '0, now_time = '0;
    logic [31:0] rd_data;
    logic [NC*32-1:0] interp_o, rate_m_o, rate_n_o, cfg_o, freq_o, scale_o, tincr_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    duc_cfg_bank #(.ADDR_W(AW), .TIME_W(TW), .NCHAN(NC), .NUM_HB(NHB), .CIC_MAX(CMAX),
                   .COMPAT_MAJOR(MAJ), .COMPAT_MINOR(MIN)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_timed(wr_timed), .wr_time(wr_time), .now_time(now_time),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .interp_o(interp_o), .rate_m_o(rate_m_o), .rate_n_o(rate_n_o), .cfg_o(cfg_o),
        .freq_o(freq_o), .scale_o(scale_o), .tincr_o(tincr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sl(input logic [NC*32-1:0] b, input int c);
        return b[c*32 +: 32];
    endfunction

    function automatic logic [AW-1:0] adr(input int ch, input int idx);
        return AW'(ch * 2048 + idx * 8);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                      input bit t, input logic [TW-1:0] tm);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; wr_timed = t; wr_time = tm;
        @(negedge clk);
        wr_en = 0; wr_timed = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    function automatic logic [31:0] reset_val(input int ch, input int idx);
        if (ch >= NC) return 0;
        case (idx)
            0: return {MAJ[15:0], MIN[15:0]};
            1: return NHB;
            2: return CMAX;
            128, 129, 131: return 1;
            133: return 32'h8000;
            default: return 0;
        endcase
    endfunction

    initial begin
        logic [31:0] r, exp_i, w;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            chk("R1 interp", sl(interp_o, c), 1);
            chk("R1 rate_m", sl(rate_m_o, c), 1);
            chk("R1 rate_n", sl(rate_n_o, c), 1);
            chk("R1 cfg", sl(cfg_o, c), 0);
            chk("R1 freq", sl(freq_o, c), 0);
            chk("R1 scale", sl(scale_o, c), 32'h8000);
            chk("R1 tincr", sl(tincr_o, c), 0);
        end
        // R5 R6 sweep of all aligned offsets in real and missing banks
        for (int c = 0; c < NC + 1; c++)
            for (int i = 0; i < 256; i++) begin
                rd(adr(c, i), r);
                chk((i < 3) ? "R5 id word" : "R6 readback sweep", r, reset_val(c, i));
            end
        for (int m = 1; m < 8; m++) begin
            rd(AW'(m), r);
            chk("R6 misaligned read", r, 0);
        end
        // R4 interpolation sweep
        exp_i = 1;
        for (int hb = 0; hb < 4; hb++)
            for (int cic = 0; cic < 10; cic++) begin
                w = {16'h5A5A, 8'(hb), 8'(cic)};
                wr(adr(0, 131), w, 0, 0);
                if (hb <= NHB && cic >= 1 && cic <= CMAX) exp_i = {16'h0, w[15:0]};
                chk("R4 interp out", sl(interp_o, 0), exp_i);
                chk("R4 other channel", sl(interp_o, 1), 1);
            end
        rd(adr(0, 131), r);
        chk("R4 interp readback", r, exp_i);
        // R3 R2 each register per channel
        for (int c = 0; c < NC; c++) begin
            logic [31:0] base;
            base = 32'h1000_0000 * (c + 1);
            wr(adr(c, 128), base + 1, 0, 0);
            wr(adr(c, 129), base + 2, 0, 0);
            wr(adr(c, 130), base + 3, 0, 0);
            wr(adr(c, 132), base + 4, 1, 0);
            wr(adr(c, 133), base + 5, 1, 16'hFFFF);
            wr(adr(c, 137), base + 6, 0, 0);
            chk("R3 rate_n", sl(rate_n_o, c), base + 1);
            chk("R3 rate_m", sl(rate_m_o, c), base + 2);
            chk("R3 cfg", sl(cfg_o, c), base + 3);
            chk("R8 timed at now", sl(freq_o, c), base + 4);
            chk("R8 timed flag on scale", sl(scale_o, c), base + 5);
            chk("R3 tincr", sl(tincr_o, c), base + 6);
            rd(adr(c, 137), r);
            chk("R3 tincr readback", r, base + 6);
            rd(adr(c, 129), r);
            chk("R3 rate_m readback", r, base + 2);
        end
        chk("R2 ch0 untouched by ch1", sl(cfg_o, 0), 32'h1000_0003);
        chk("R2 ch1 scale", sl(scale_o, 1), 32'h2000_0005);
        // R6 writes ignored
        wr(adr(2, 133), 32'hDEAD, 0, 0);
        wr(adr(0, 133) + 4, 32'hBEEF, 0, 0);
        wr(adr(0, 134), 32'hCAFE, 0, 0);
        wr(adr(0, 1), 32'h77, 0, 0);
        chk("R6 ignored ch0 scale", sl(scale_o, 0), 32'h1000_0005);
        chk("R6 ignored ch1 scale", sl(scale_o, 1), 32'h2000_0005);
        rd(adr(0, 1), r);
        chk("R6 id not writable", r, NHB);
        rd(adr(0, 134), r);
        chk("R6 undefined index", r, 0);
        // R7 timed future
        now_time = 100;
        wr(adr(1, 132), 32'h0000_ABCD, 1, 110);
        chk("R7 held pending", sl(freq_o, 1), 32'h2000_0004);
        wr(adr(1, 132), 32'h0000_1234, 1, 110);
        now_time = 109;
        @(negedge clk);
        chk("R7 still pending", sl(freq_o, 1), 32'h2000_0004);
        now_time = 110;
        @(negedge clk);
        chk("R7 commits at time", sl(freq_o, 1), 32'h0000_1234);
        chk("R7 ch0 unaffected", sl(freq_o, 0), 32'h1000_0004);
        // R8 past time
        now_time = 200;
        wr(adr(0, 132), 32'h0000_5555, 1, 150);
        chk("R8 past time immediate", sl(freq_o, 0), 32'h0000_5555);
        // R9 untimed cancels
        wr(adr(0, 132), 32'h0000_6666, 1, 300);
        wr(adr(0, 132), 32'h0000_7777, 0, 0);
        chk("R9 untimed applies", sl(freq_o, 0), 32'h0000_7777);
        now_time = 300;
        repeat (2) @(negedge clk);
        chk("R9 pending discarded", sl(freq_o, 0), 32'h0000_7777);
        // R10 hold
        rd(adr(0, 132), r);
        chk("R10 read value", r, 32'h0000_7777);
        rd_addr = adr(0, 0);
        repeat (2) @(negedge clk);
        chk("R10 hold without rd_en", rd_data, 32'h0000_7777);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule